// File: doc/BRIEF.md
# Power Port Event and Interrupt Aggregator

This block collects fault observations from eight power ports and from one global supervisor that watches the supply and the die temperature. Each measurement source delivers a strobe with two fault flags. The block keeps the latest flags as a status register and records each new fault as a sticky event bit. Each event register can be read at two addresses. One address leaves the bits in place. The other returns the bits and clears them in the same access.

A host enable register chooses which sources can raise the interrupt. The sources are serviced in a fixed round-robin schedule: eight ports first, then the global source. Each source gets a four-cycle slot. In that slot the status is written first, then the event bits, then that source's interrupt-register bit, and last the active-low pin. Because of this schedule the pin always trails the event registers and never follows them combinationally. The register bus is a simple read/write strobe port with combinational read data. A clearing read takes effect at the clock edge on which the read strobe is high.

Top module: `port_evt_irq`

## Requirements
- R1: After reset, every status, event, interrupt-register and enable bit reads 0 and `irq_n` is 1.
- R2: A strobe from a source latches its two flags as pending. At phase 0 of that source's slot, the pending flags become its status register, which holds bit 0 = current limit and bit 1 = short circuit for a port, and bit 0 = undervoltage lockout and bit 1 = over-temperature for the global source.
- R3: At phase 1 of a source's slot, each status bit that went from 0 to 1 at phase 0 sets the matching event bit. A flag that stays at 1 does not set the event again after it has been cleared.
- R4: Event bits are sticky: a normal read, a change of enable, or a fault that goes away leaves them set.
- R5: A clearing read returns the current event bits and clears them at that clock edge.
- R6: If a clearing read happens on the same edge that sets an event bit, the newly set bit stays 1 while the older bits are cleared.
- R7: At phase 2 of slot s, interrupt-register bit s is loaded with enable[s] AND (OR of the event bits of s). Bit 8 belongs to the global source.
- R8: At phase 3 of every slot, `irq_n` is loaded with the NOR of the interrupt register. At any other time it holds its value.
- R9: Slots run in the order port 0 to port 7, then the global source, with 4 cycles per slot. The first edge after reset is port 0, phase 0. An event becomes visible one edge after its status, the interrupt-register bit follows one edge later, and the pin one edge after that.
- R10: Address map, with a[4:3] as group and a[2:0] as index. Group 0: index 0 = interrupt register, 1 = enable (read/write, bit s enables source s), 2 = global status, 3 = global event, 4 = global event with clear. Group 1 = port status, group 2 = port event, group 3 = port event with clear, each indexed by port number.
- R11: A second strobe from the same source before its slot comes round replaces the pending flags, and only the last flags reach the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_done | input | NPORT | Per-port measurement-complete strobe |
| ilim_flt | input | NPORT | Per-port current-limit flag, sampled with the strobe |
| short_flt | input | NPORT | Per-port short-circuit flag, sampled with the strobe |
| sup_done | input | 1 | Global supervisor strobe |
| uvlo_flt | input | 1 | Supply undervoltage flag, sampled with the supervisor strobe |
| therm_flt | input | 1 | Over-temperature flag, sampled with the supervisor strobe |
| bus_addr | input | 5 | Register address |
| bus_rd | input | 1 | Read strobe (a clearing address clears at the edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPORT+1 | Write data for the enable register |
| bus_rdata | output | NPORT+1 | Combinational read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a clearing read that lands on exactly the edge where the same source's event phase sets a new bit, because that edge comes round only once per 36-cycle round. The bench works out the slot and phase of every edge from the fixed schedule and a count of edges since reset. It first raises a fault and lets it settle, then sends a second fault that adds a new flag, waits for the event phase of that port, and issues the clearing read on that edge. The same edge count is used to step cycle by cycle through status, event, interrupt register and pin, which confirms the order of the updates.

// File: rtl/port_evt_irq.sv
module port_evt_irq #(
  parameter int NPORT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] meas_done,
  input  logic [NPORT-1:0] ilim_flt,
  input  logic [NPORT-1:0] short_flt,
  input  logic             sup_done,
  input  logic             uvlo_flt,
  input  logic             therm_flt,
  input  logic [4:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [NPORT:0]   bus_wdata,
  output logic [NPORT:0]   bus_rdata,
  output logic             irq_n
);
  localparam int NSRC = NPORT + 1;
  localparam int SW   = $clog2(NSRC);

  logic [1:0]      grp;
  logic [2:0]      idx;
  logic [NSRC-1:0] stb, pend_v, cor_hit, svc, ien, irq_reg;
  logic [1:0]      fin    [NSRC];
  logic [1:0]      pend_f [NSRC];
  logic [1:0]      stat   [NSRC];
  logic [1:0]      evt    [NSRC];
  logic [1:0]      rise   [NSRC];
  logic [1:0]      prv, cur_stat, ph;
  logic [SW-1:0]   sel;
  logic            ien_we;

  assign grp    = bus_addr[4:3];
  assign idx    = bus_addr[2:0];
  assign ien_we = bus_wr && grp == 2'd0 && idx == 3'd1;

  assign stb[NPORT]     = sup_done;
  assign fin[NPORT]     = {therm_flt, uvlo_flt};
  assign cor_hit[NPORT] = bus_rd && grp == 2'd0 && idx == 3'd4;

  always_comb begin
    cur_stat = '0;
    for (int k = 0; k < NSRC; k++)
      if (sel == SW'(k)) cur_stat = stat[k];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < NPORT) begin : g_port
      assign stb[i]     = meas_done[i];
      assign fin[i]     = {short_flt[i], ilim_flt[i]};
      assign cor_hit[i] = bus_rd && grp == 2'd3 && idx == 3'(i);
    end
    assign svc[i]  = (sel == SW'(i));
    assign rise[i] = (svc[i] && ph == 2'd1) ? (stat[i] & ~prv) : 2'b00;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_v[i] <= 1'b0;
        pend_f[i] <= '0;
        stat[i]   <= '0;
        evt[i]    <= '0;
      end else begin
        if (stb[i]) begin
          pend_v[i] <= 1'b1;
          pend_f[i] <= fin[i];
        end else if (svc[i] && ph == 2'd0) begin
          pend_v[i] <= 1'b0;
        end
        if (svc[i] && ph == 2'd0 && pend_v[i]) stat[i] <= pend_f[i];
        evt[i] <= (evt[i] & ~{2{cor_hit[i]}}) | rise[i];
      end
    end

    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cor_hit[i] |=> (evt[i] & $past(evt[i])) == $past(evt[i]));
    // R9
    evt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] & ~$past(evt[i])) != 2'b00 |-> $past(svc[i] && ph == 2'd1));
    // R6
    cor_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cor_hit[i] && rise[i] != 2'b00) |=> (evt[i] & $past(rise[i])) == $past(rise[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      sel     <= '0;
      prv     <= '0;
      ien     <= '0;
      irq_reg <= '0;
      irq_n   <= 1'b1;
    end else begin
      ph <= ph + 2'd1;
      if (ph == 2'd3) sel <= (sel == SW'(NSRC - 1)) ? '0 : sel + 1'b1;
      if (ph == 2'd0) prv <= cur_stat;
      if (ph == 2'd2)
        for (int k = 0; k < NSRC; k++)
          if (sel == SW'(k)) irq_reg[k] <= ien[k] & (|evt[k]);
      if (ph == 2'd3) irq_n <= ~|irq_reg;
      if (ien_we) ien <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (grp == 2'd0) begin
      case (idx)
        3'd0: bus_rdata = irq_reg;
        3'd1: bus_rdata = ien;
        3'd2: bus_rdata[1:0] = stat[NPORT];
        3'd3, 3'd4: bus_rdata[1:0] = evt[NPORT];
        default: bus_rdata = '0;
      endcase
    end else begin
      for (int k = 0; k < NPORT; k++)
        if (idx == 3'(k)) bus_rdata[1:0] = (grp == 2'd1) ? stat[k] : evt[k];
    end
  end

  // R8
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 2'd3 |=> irq_n == !$past(|irq_reg));
  // R8
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd3 |=> $stable(irq_n));
  // R7
  irq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd2 |=> $stable(irq_reg));
endmodule

// File: tb/sim_port_evt_irq.sv
module sim_port_evt_irq;
  localparam int NP = 8;
  localparam int NS = NP + 1;
  localparam int ROUND = 4 * NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] meas_done = '0, ilim_flt = '0, short_flt = '0;
  logic sup_done = 1'b0, uvlo_flt = 1'b0, therm_flt = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [NP:0] bus_wdata = '0;
  logic [NP:0] bus_rdata;
  logic irq_n;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [8:0] d;

  port_evt_irq #(.NPORT(NP)) u0 (.*);

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [4:0] st_a(int s);  return (s == NP) ? 5'd2 : 5'(8 + s);  endfunction
  function automatic logic [4:0] ev_a(int s);  return (s == NP) ? 5'd3 : 5'(16 + s); endfunction
  function automatic logic [4:0] cor_a(int s); return (s == NP) ? 5'd4 : 5'(24 + s); endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] a, output logic [8:0] q);
    bus_addr = a; bus_rd = 1'b1; #1; q = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic cor_rd(input logic [4:0] a, output logic [8:0] q);
    bus_addr = a; bus_rd = 1'b1; #1; q = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr_ien(input logic [8:0] v);
    bus_addr = 5'd1; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic strobe(input int s, input logic [1:0] f);
    if (s == NP) begin sup_done = 1'b1; uvlo_flt = f[0]; therm_flt = f[1]; end
    else begin meas_done[s] = 1'b1; ilim_flt[s] = f[0]; short_flt[s] = f[1]; end
    @(negedge clk);
    meas_done = '0; sup_done = 1'b0;
  endtask

  task automatic goto_slot(input int s, input int p);
    while (!((cyc % 4) == p && ((cyc / 4) % NS) == s)) @(negedge clk);
  endtask

  task automatic settle; repeat (2 * ROUND) @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < NS; s++) begin
      peek(st_a(s), d); chk("R1 status", d, 9'h0);
      peek(ev_a(s), d); chk("R1 event", d, 9'h0);
    end
    peek(5'd0, d); chk("R1 irq reg", d, 9'h0);
    peek(5'd1, d); chk("R1 enable", d, 9'h0);
    chk("R1 pin", {8'h0, irq_n}, 9'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: enable register readback
    wr_ien(9'h1FF);
    peek(5'd1, d); chk("R10 enable readback", d, 9'h1FF);

    // sweep every source and fault bit
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < 2; b++) begin
        strobe(s, 2'(1 << b)); settle;
        peek(st_a(s), d); chk("R2 status", d, 9'(1 << b));
        peek(ev_a(s), d); chk("R3 event set", d, 9'(1 << b));
        peek(ev_a(s), d); chk("R4 normal read keeps", d, 9'(1 << b));
        peek(5'd0, d); chk("R7 irq reg", d, 9'(1 << s));
        chk("R8 pin low", {8'h0, irq_n}, 9'h0);
        cor_rd(cor_a(s), d); chk("R5 clear read data", d, 9'(1 << b));
        peek(ev_a(s), d); chk("R5 cleared", d, 9'h0);
        settle;
        peek(5'd0, d); chk("R7 irq reg cleared", d, 9'h0);
        chk("R8 pin high", {8'h0, irq_n}, 9'h1);
        strobe(s, 2'(1 << b)); settle;
        peek(ev_a(s), d); chk("R3 held level no event", d, 9'h0);
        strobe(s, 2'b00); settle;
        peek(st_a(s), d); chk("R2 status clear", d, 9'h0);
        peek(ev_a(s), d); chk("R4 fault gone keeps", d, 9'h0);
      end
    end

    // R7 masking with alternating enables
    wr_ien(9'h0AA);
    for (int s = 0; s < NS; s++) strobe(s, 2'b01);
    settle;
    peek(5'd0, d); chk("R7 masked irq reg", d, 9'h0AA);
    chk("R8 pin low masked", {8'h0, irq_n}, 9'h0);
    wr_ien(9'h000); settle;
    peek(5'd0, d); chk("R7 all masked", d, 9'h0);
    chk("R8 pin high all masked", {8'h0, irq_n}, 9'h1);
    peek(ev_a(0), d); chk("R4 mask keeps event", d, 9'h1);
    wr_ien(9'h1FF);
    for (int s = 0; s < NS; s++) begin
      cor_rd(cor_a(s), d); strobe(s, 2'b00);
    end
    settle;

    // R9: stepwise order through status, event, irq reg, pin
    goto_slot(0, 0);
    strobe(5, 2'b01);
    goto_slot(5, 0);
    peek(st_a(5), d); chk("R9 status before", d, 9'h0);
    @(negedge clk);
    peek(st_a(5), d); chk("R9 status updated", d, 9'h1);
    peek(ev_a(5), d); chk("R9 event not yet", d, 9'h0);
    @(negedge clk);
    peek(ev_a(5), d); chk("R9 event updated", d, 9'h1);
    peek(5'd0, d); chk("R9 irq reg not yet", d, 9'h0);
    chk("R9 pin not yet", {8'h0, irq_n}, 9'h1);
    @(negedge clk);
    peek(5'd0, d); chk("R9 irq reg updated", d, 9'h020);
    chk("R9 pin still high", {8'h0, irq_n}, 9'h1);
    @(negedge clk);
    chk("R9 pin low", {8'h0, irq_n}, 9'h0);
    cor_rd(cor_a(5), d); strobe(5, 2'b00); settle;
    chk("R8 pin released", {8'h0, irq_n}, 9'h1);

    // R6: clearing read on the setting edge
    goto_slot(0, 0);
    strobe(2, 2'b01); settle;
    peek(ev_a(2), d); chk("R6 first event", d, 9'h1);
    goto_slot(0, 0);
    strobe(2, 2'b11);
    goto_slot(2, 1);
    cor_rd(cor_a(2), d); chk("R6 read data", d, 9'h1);
    peek(ev_a(2), d); chk("R6 new event survives", d, 9'h2);
    cor_rd(cor_a(2), d); strobe(2, 2'b00); settle;
    cor_rd(cor_a(2), d);

    // R11: later strobe replaces pending flags
    goto_slot(0, 0);
    strobe(4, 2'b01);
    strobe(4, 2'b10);
    settle;
    peek(st_a(4), d); chk("R11 last flags", d, 9'h2);
    peek(ev_a(4), d); chk("R11 only last event", d, 9'h2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule